// File: doc/BRIEF.md
# Framing Path Violation Counter

This block counts framing-path code violations for a T1/E1 receive framer. The framing mode picks which error strobe counts. In T1 superframe mode, Ft pattern errors always count, and Fs pattern errors count only when an option bit is set. In T1 extended superframe mode, CRC-6 codeword errors count. In E1 mode, CRC-4 errors count.

In E1 mode, counting stops while sync is lost at the FAS level or at the CRC-4 multiframe level. A loss of CAS multiframe sync alone does not stop it.

A one-second strobe copies the running count into a period register and restarts the running count. The framer logic sits on one side of the block and the host register file on the other. Both counts are 16 bits by default and stop at all-ones instead of wrapping.

Top module: `pcv_counter`

## Requirements
- R1: With `mode_i` = 0 (T1 SF) and `fs_count_en_i` = 0, each cycle with `ft_err_i` high adds one to the running count. `fs_err_i`, `crc6_err_i` and `crc4_err_i` have no effect.
- R2: With `mode_i` = 0 and `fs_count_en_i` = 1, `ft_err_i` and `fs_err_i` each add one. When both are high in the same cycle, the running count advances by two.
- R3: With `mode_i` = 1 (T1 ESF), each cycle with `crc6_err_i` high adds one. `fs_count_en_i`, `ft_err_i`, `fs_err_i` and `crc4_err_i` have no effect.
- R4: With `mode_i` = 2 (E1), each cycle with `crc4_err_i` high adds one. The T1 strobes have no effect.
- R5: In E1 mode, no event is counted while `fas_loss_i` or `crc4_mf_loss_i` is high.
- R6: In E1 mode, with the default `CAS_HALTS` = 0, a high `cas_mf_loss_i` alone does not stop counting.
- R7: A cycle with `sec_latch_i` high has two effects. `period_count_o` takes the running count from before that cycle. The running count restarts and holds only the events of that same cycle. `period_count_o` holds its value in every other cycle.
- R8: The running count stops at 2^CNT_W-1 and does not wrap.
- R9: With `mode_i` = 3, nothing is counted.
- R10: After reset, both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 T1 SF, 1 T1 ESF, 2 E1, 3 off |
| fs_count_en_i | input | 1 | Count Fs errors in T1 SF |
| ft_err_i | input | 1 | Ft pattern error strobe |
| fs_err_i | input | 1 | Fs pattern error strobe |
| crc6_err_i | input | 1 | CRC-6 codeword error strobe |
| crc4_err_i | input | 1 | CRC-4 error strobe |
| fas_loss_i | input | 1 | FAS sync lost |
| crc4_mf_loss_i | input | 1 | CRC-4 multiframe sync lost |
| cas_mf_loss_i | input | 1 | CAS multiframe sync lost |
| sec_latch_i | input | 1 | One-second latch strobe |
| live_count_o | output | CNT_W | Running count |
| period_count_o | output | CNT_W | Count of the last closed period |

## Verification
The bench builds the block with CNT_W = 4 and keeps `CAS_HALTS` at its default of 0. With a limit of 15, twenty events are enough to drive the running count into saturation and to check that a double increment stops at the limit rather than wrapping. The default of 0 is the setting in which a CAS-only loss must leave E1 counting running.

// File: rtl/pcv_pkg.sv
package pcv_pkg;
  typedef enum logic [1:0] {
    MODE_T1_SF  = 2'd0,
    MODE_T1_ESF = 2'd1,
    MODE_E1     = 2'd2,
    MODE_OFF    = 2'd3
  } frm_mode_e;

  localparam int unsigned INC_W = 2;
endpackage

// File: rtl/pcv_event_sel.sv
module pcv_event_sel
  import pcv_pkg::*;
#(
  parameter bit CAS_HALTS = 1'b0
) (
  input  frm_mode_e        mode_i,
  input  logic             fs_count_en_i,
  input  logic             ft_err_i,
  input  logic             fs_err_i,
  input  logic             crc6_err_i,
  input  logic             crc4_err_i,
  input  logic             fas_loss_i,
  input  logic             crc4_mf_loss_i,
  input  logic             cas_mf_loss_i,
  output logic [INC_W-1:0] incr_o
);
  logic e1_halt;

  generate
    if (CAS_HALTS) begin : g_cas_halts
      assign e1_halt = fas_loss_i | crc4_mf_loss_i | cas_mf_loss_i;
    end else begin : g_cas_free
      // CAS multiframe loss does not stop CRC-4 error counting
      logic cas_unused;
      assign cas_unused = cas_mf_loss_i;
      assign e1_halt    = fas_loss_i | crc4_mf_loss_i | (cas_unused & 1'b0);
    end
  endgenerate

  always_comb begin
    incr_o = '0;
    unique case (mode_i)
      MODE_T1_SF:  incr_o = {1'b0, ft_err_i} + {1'b0, fs_err_i & fs_count_en_i};
      MODE_T1_ESF: incr_o = {1'b0, crc6_err_i};
      MODE_E1:     incr_o = {1'b0, crc4_err_i & ~e1_halt};
      default:     incr_o = '0;
    endcase
  end
endmodule

// File: rtl/pcv_sat_acc.sv
module pcv_sat_acc
  import pcv_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] incr_i,
  input  logic             latch_i,
  output logic [CNT_W-1:0] live_o,
  output logic [CNT_W-1:0] held_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] live_nxt;

  assign sum = {1'b0, live_o} + {{(CNT_W+1-INC_W){1'b0}}, incr_i};

  always_comb begin
    if (latch_i)
      live_nxt = {{(CNT_W-INC_W){1'b0}}, incr_i};
    else if (sum[CNT_W])
      live_nxt = CNT_MAX;
    else
      live_nxt = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_o <= '0;
      held_o <= '0;
    end else begin
      live_o <= live_nxt;
      if (latch_i) held_o <= live_o;
    end
  end
endmodule

// File: rtl/pcv_counter.sv
module pcv_counter
  import pcv_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter bit          CAS_HALTS = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             fs_count_en_i,
  input  logic             ft_err_i,
  input  logic             fs_err_i,
  input  logic             crc6_err_i,
  input  logic             crc4_err_i,
  input  logic             fas_loss_i,
  input  logic             crc4_mf_loss_i,
  input  logic             cas_mf_loss_i,
  input  logic             sec_latch_i,
  output logic [CNT_W-1:0] live_count_o,
  output logic [CNT_W-1:0] period_count_o
);
  logic [INC_W-1:0] incr;

  pcv_event_sel #(.CAS_HALTS(CAS_HALTS)) u_sel (
    .mode_i         (frm_mode_e'(mode_i)),
    .fs_count_en_i  (fs_count_en_i),
    .ft_err_i       (ft_err_i),
    .fs_err_i       (fs_err_i),
    .crc6_err_i     (crc6_err_i),
    .crc4_err_i     (crc4_err_i),
    .fas_loss_i     (fas_loss_i),
    .crc4_mf_loss_i (crc4_mf_loss_i),
    .cas_mf_loss_i  (cas_mf_loss_i),
    .incr_o         (incr)
  );

  pcv_sat_acc #(.CNT_W(CNT_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .incr_i  (incr),
    .latch_i (sec_latch_i),
    .live_o  (live_count_o),
    .held_o  (period_count_o)
  );
endmodule

// File: rtl/pcv_counter_checker.sv
module pcv_counter_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             crc6_err_i,
  input logic             fas_loss_i,
  input logic             crc4_mf_loss_i,
  input logic             sec_latch_i,
  input logic [CNT_W-1:0] live_count_o,
  input logic [CNT_W-1:0] period_count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W+1:0] live_ext;
  assign live_ext = {2'b00, live_count_o};

  assert_latch_copy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_latch_i |=> period_count_o == $past(live_count_o));

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_latch_i |=> live_count_o <= CNT_W'(2));

  assert_held_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_latch_i |=> $stable(period_count_o));

  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_count_o == CNT_MAX && !sec_latch_i) |=> live_count_o == CNT_MAX);

  assert_step_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_latch_i |=> (live_ext >= $past(live_ext)) && (live_ext <= $past(live_ext) + 2));

  assert_e1_halt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && (fas_loss_i || crc4_mf_loss_i) && !sec_latch_i) |=> $stable(live_count_o));

  assert_esf_only_crc6_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && !crc6_err_i && !sec_latch_i) |=> $stable(live_count_o));

  assert_off_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && !sec_latch_i) |=> $stable(live_count_o));
endmodule

bind pcv_counter pcv_counter_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_i         (mode_i),
  .crc6_err_i     (crc6_err_i),
  .fas_loss_i     (fas_loss_i),
  .crc4_mf_loss_i (crc4_mf_loss_i),
  .sec_latch_i    (sec_latch_i),
  .live_count_o   (live_count_o),
  .period_count_o (period_count_o)
);

// File: tb/pcv_counter_bench.sv
module pcv_counter_bench;
  localparam int unsigned CNT_W = 4;
  localparam int MAXV = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic fs_en = 0, ft = 0, fs = 0, c6 = 0, c4 = 0;
  logic fas = 0, mfl = 0, cas = 0, lat = 0;
  logic [CNT_W-1:0] live, held;

  int checks = 0;
  int errors = 0;
  int model = 0;
  int q_exp[$];
  string q_tag[$];
  bit done = 0;

  always #10 clk = ~clk;

  pcv_counter #(.CNT_W(CNT_W)) u_pcv_counter (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .fs_count_en_i(fs_en),
    .ft_err_i(ft), .fs_err_i(fs), .crc6_err_i(c6), .crc4_err_i(c4),
    .fas_loss_i(fas), .crc4_mf_loss_i(mfl), .cas_mf_loss_i(cas),
    .sec_latch_i(lat), .live_count_o(live), .period_count_o(held)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected increment, taken from the requirements
  function automatic int exp_incr();
    case (mode)
      2'd0: return int'(ft) + ((fs_en && fs) ? 1 : 0);
      2'd1: return int'(c6);
      2'd2: return (c4 && !fas && !mfl) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  // driver: inputs already set after a falling edge; one clock, then check
  task automatic tick(string tag);
    int inc = exp_incr();
    if (lat) begin
      q_exp.push_back(model);
      q_tag.push_back(tag);
      model = inc;
    end else begin
      model = (model + inc > MAXV) ? MAXV : model + inc;
    end
    @(negedge clk);
    check({tag, " live"}, int'(live), model);
    ft = 0; fs = 0; c6 = 0; c4 = 0; lat = 0;
  endtask

  // monitor: compares the period register after each latch
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && lat) begin
        @(negedge clk);
        if (q_exp.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 unexpected latch actual=%0d expected=none", held);
        end else begin
          check({q_tag.pop_front(), " period"}, int'(held), q_exp.pop_front());
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 live reset", int'(live), 0);
    check("R10 period reset", int'(held), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: SF, Fs option off
    mode = 2'd0; fs_en = 0;
    ft = 1; tick("R1 ft");
    ft = 1; tick("R1 ft");
    fs = 1; c6 = 1; c4 = 1; tick("R1 others ignored");
    // R2: SF, Fs option on
    fs_en = 1;
    fs = 1; tick("R2 fs");
    ft = 1; fs = 1; tick("R2 both add two");
    lat = 1; tick("R7 close SF period");
    // R3: ESF
    mode = 2'd1; fs_en = 1;
    ft = 1; fs = 1; c4 = 1; tick("R3 non-crc6 ignored");
    c6 = 1; tick("R3 crc6");
    fs_en = 0; c6 = 1; tick("R3 option ignored");
    // R4..R6: E1
    mode = 2'd2;
    c4 = 1; tick("R4 crc4");
    ft = 1; fs = 1; c6 = 1; tick("R4 t1 strobes ignored");
    fas = 1; c4 = 1; tick("R5 fas loss halts");
    fas = 0; mfl = 1; c4 = 1; tick("R5 crc4 mf loss halts");
    mfl = 0; cas = 1; c4 = 1; tick("R6 cas loss counts");
    cas = 0;
    // R7: event in latch cycle belongs to new period
    c4 = 1; lat = 1; tick("R7 latch with event");
    c4 = 1; tick("R7 new period");
    // R9: off mode
    mode = 2'd3;
    ft = 1; fs = 1; c6 = 1; c4 = 1; tick("R9 off mode");
    // R8: saturation
    mode = 2'd0; fs_en = 1;
    for (int i = 0; i < 10; i++) begin
      ft = 1; fs = 1; tick("R8 fill");
    end
    ft = 1; tick("R8 stays at max");
    check("R8 at max", int'(live), MAXV);
    lat = 1; ft = 1; fs = 1; tick("R8 R7 latch saturated");
    tick("R7 idle hold");
    check("R7 period held", int'(held), MAXV);
    lat = 1; tick("R7 second latch");
    repeat (2) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule